// File: doc/BRIEF.md
# Processor Control Decoder with Branch and Trap Overrides

This block is the instruction decoder of a single-cycle 32-bit processor. It takes the six-bit opcode field of the instruction being executed and produces every select and enable the datapath needs for that cycle: the operand source muxes, the second register-read address source, the ALU function code, the write-back source and destination, the register-file write enable, the data memory read and write enables, and the next-PC source.

Base control words come from a 64-entry table. The table is computed at elaboration time, not written out by hand. Three overrides follow the table. First, the two conditional branches are resolved on the zero flag of the first register operand. Second, an interrupt request is taken only while the PC's top (supervisor) bit is clear. Third, reset blocks every write into the register file and data memory, so memory never sees an undefined write enable at a clock edge.

The block is purely combinational. Its outputs settle within the cycle that the opcode, the zero flag and the request inputs are presented.

Top module: `ctl_decoder`

## Requirements
- R1: Every opcode without a defined meaning gives next-PC select 011, write-address select 1, register write enable 1 and write-data select 00. All other fields are 0. The undefined opcodes are 000000 to 010111, 011010, 011100, and 10xxxx or 11xxxx whose low nibble is 0011, 0111 or 1111.
- R2: Opcode 011000 (load) gives B select 1, ALU function 000000, write-data select 10, register write enable 1 and memory read enable 1. All other fields are 0.
- R3: Opcode 011001 (store) gives B select 1, second-read-address select 1, ALU function 000000 and memory write enable 1. All other fields are 0.
- R4: Opcode 011011 (jump) gives next-PC select 010, write-data select 00 and register write enable 1. All other fields are 0.
- R5: Opcode 011101 (branch if equal) gives register write enable 1 and write-data select 00. Next-PC select is 001 when zero is 1 and 000 when zero is 0. All other fields are 0.
- R6: Opcode 011110 (branch if not equal) behaves like R5, except that next-PC select is 001 when zero is 0 and 000 when zero is 1.
- R7: Opcode 011111 (PC-relative load) gives A select 1, ALU function 011010, write-data select 10, register write enable 1 and memory read enable 1. All other fields are 0.
- R8: Opcodes 10xxxx and 11xxxx with a defined low nibble give register write enable 1 and write-data select 01. B select equals opcode bit 4. The ALU function maps from the low nibble as follows: 0→000000, 1→000001, 2→000010, 4→110011, 5→110101, 6→110111, 8→011000, 9→011110, A→010110, B→011001, C→100000, D→100001, E→100011. All other fields are 0.
- R9: When the interrupt request is 1 and the supervisor bit is 0, the block forces next-PC select 100, write-address select 1, register write enable 1, write-data select 00 and memory write enable 0. The other fields keep their table values.
- R10: While the supervisor bit is 1, the interrupt request changes no output.
- R11: While reset is 1, memory write enable and register write enable are 0. Every other output has the value it would have with reset at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Opcode field of the current instruction |
| zero_flag | input | 1 | 1 when the first register operand equals zero |
| rst | input | 1 | Active-high reset |
| irq_req | input | 1 | Interrupt request |
| pc_sup | input | 1 | Current PC bit 31 (supervisor mode) |
| sel_a | output | 1 | A operand select (1 = branch-offset address) |
| sel_b | output | 1 | B operand select (1 = sign-extended constant) |
| sel_rb_addr | output | 1 | Second read address select (1 = destination field) |
| alu_fn | output | 6 | ALU function code |
| mem_rd_en | output | 1 | Data memory read enable |
| wd_sel | output | 2 | Write-back source: 00 PC+4, 01 ALU, 10 memory data |
| wa_sel_xp | output | 1 | Write address select (1 = exception register) |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| npc_sel | output | 3 | Next-PC source |

## Verification
Several overrides can land on the same instruction. An interrupt can arrive while a conditional branch is resolving or while a store is requesting a memory write, and reset can coincide with a taken interrupt. The bench reaches all of these by sweeping every opcode against every combination of zero flag, reset, interrupt request and supervisor bit. Each vector's full 18-bit control word is judged against a model written from the priority order: the table first, then branch resolution, then interrupt injection, then the reset write block. A vector where the interrupt and reset are both active must therefore show the trap next-PC select and the exception write address together with both write enables low.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int NPC_W  = 3;
  localparam int WD_W   = 2;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic [NPC_W-1:0] pcsel;
    logic             wasel;
    logic             asel;
    logic             ra2sel;
    logic             bsel;
    logic [FN_W-1:0]  alufn;
    logic [WD_W-1:0]  wdsel;
    logic             werf;
    logic             moe;
    logic             wr;
  } ctl_word_t;

  localparam logic [NPC_W-1:0] NPC_SEQ = 3'd0;
  localparam logic [NPC_W-1:0] NPC_BR  = 3'd1;
  localparam logic [NPC_W-1:0] NPC_JT  = 3'd2;
  localparam logic [NPC_W-1:0] NPC_ILL = 3'd3;
  localparam logic [NPC_W-1:0] NPC_IRQ = 3'd4;

  localparam logic [WD_W-1:0] WD_PC4 = 2'd0;
  localparam logic [WD_W-1:0] WD_ALU = 2'd1;
  localparam logic [WD_W-1:0] WD_MEM = 2'd2;

  localparam logic [OP_W-1:0] OP_LOAD  = 6'b011000;
  localparam logic [OP_W-1:0] OP_STORE = 6'b011001;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b011011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b011101;
  localparam logic [OP_W-1:0] OP_BNE   = 6'b011110;
  localparam logic [OP_W-1:0] OP_PCLD  = 6'b011111;

  localparam logic [FN_W-1:0] FN_ADD  = 6'b000000;
  localparam logic [FN_W-1:0] FN_PASS = 6'b011010;

  // Returns {defined, function code} for an ALU-class low nibble.
  function automatic logic [FN_W:0] alu_lookup(input logic [NIB_W-1:0] nib);
    logic [FN_W:0] r;
    case (nib)
      4'h0: r = {1'b1, 6'b000000};
      4'h1: r = {1'b1, 6'b000001};
      4'h2: r = {1'b1, 6'b000010};
      4'h4: r = {1'b1, 6'b110011};
      4'h5: r = {1'b1, 6'b110101};
      4'h6: r = {1'b1, 6'b110111};
      4'h8: r = {1'b1, 6'b011000};
      4'h9: r = {1'b1, 6'b011110};
      4'hA: r = {1'b1, 6'b010110};
      4'hB: r = {1'b1, 6'b011001};
      4'hC: r = {1'b1, 6'b100000};
      4'hD: r = {1'b1, 6'b100001};
      4'hE: r = {1'b1, 6'b100011};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic ctl_word_t trap_word();
    ctl_word_t w;
    w = '0;
    w.pcsel = NPC_ILL;
    w.wasel = 1'b1;
    w.werf  = 1'b1;
    w.wdsel = WD_PC4;
    return w;
  endfunction

  // Base control word for one opcode, before any override.
  function automatic ctl_word_t decode_entry(input logic [OP_W-1:0] op);
    ctl_word_t     w;
    logic [FN_W:0] a;
    w = trap_word();
    a = alu_lookup(op[NIB_W-1:0]);
    if (op[OP_W-1]) begin
      if (a[FN_W]) begin
        w       = '0;
        w.werf  = 1'b1;
        w.wdsel = WD_ALU;
        w.alufn = a[FN_W-1:0];
        w.bsel  = op[OP_W-2];
      end
    end else begin
      case (op)
        OP_LOAD: begin
          w = '0; w.bsel = 1'b1; w.alufn = FN_ADD;
          w.wdsel = WD_MEM; w.werf = 1'b1; w.moe = 1'b1;
        end
        OP_STORE: begin
          w = '0; w.bsel = 1'b1; w.ra2sel = 1'b1;
          w.alufn = FN_ADD; w.wr = 1'b1;
        end
        OP_JUMP: begin
          w = '0; w.pcsel = NPC_JT; w.werf = 1'b1; w.wdsel = WD_PC4;
        end
        OP_BEQ, OP_BNE: begin
          w = '0; w.werf = 1'b1; w.wdsel = WD_PC4;
        end
        OP_PCLD: begin
          w = '0; w.asel = 1'b1; w.alufn = FN_PASS;
          w.wdsel = WD_MEM; w.werf = 1'b1; w.moe = 1'b1;
        end
        default: w = trap_word();
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/ctl_table.sv
module ctl_table
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] addr,
  output ctl_word_t       word
);
  localparam int DEPTH = 1 << OP_W;

  ctl_word_t entries [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign entries[i] = decode_entry(OP_W'(i));
  end

  assign word = entries[addr];
endmodule

// File: rtl/ctl_branch.sv
module ctl_branch
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic             zero,
  input  logic [NPC_W-1:0] pcsel_in,
  output logic [NPC_W-1:0] pcsel_out
);
  always_comb begin
    pcsel_out = pcsel_in;
    if (op == OP_BEQ)      pcsel_out = zero ? NPC_BR  : NPC_SEQ;
    else if (op == OP_BNE) pcsel_out = zero ? NPC_SEQ : NPC_BR;
  end
endmodule

// File: rtl/ctl_trap.sv
module ctl_trap
  import ctl_pkg::*;
(
  input  ctl_word_t w_in,
  input  logic      rst,
  input  logic      irq,
  input  logic      sup,
  output ctl_word_t w_out
);
  logic take_irq;
  assign take_irq = irq & ~sup;

  always_comb begin
    w_out = w_in;
    if (take_irq) begin
      w_out.pcsel = NPC_IRQ;
      w_out.wasel = 1'b1;
      w_out.werf  = 1'b1;
      w_out.wdsel = WD_PC4;
      w_out.wr    = 1'b0;
    end
    if (rst) begin
      w_out.wr   = 1'b0;
      w_out.werf = 1'b0;
    end
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic       zero_flag,
  input  logic       rst,
  input  logic       irq_req,
  input  logic       pc_sup,
  output logic       sel_a,
  output logic       sel_b,
  output logic       sel_rb_addr,
  output logic [5:0] alu_fn,
  output logic       mem_rd_en,
  output logic [1:0] wd_sel,
  output logic       wa_sel_xp,
  output logic       rf_we,
  output logic       mem_we,
  output logic [2:0] npc_sel
);
  ctl_word_t        base_w;
  ctl_word_t        br_w;
  ctl_word_t        fin_w;
  logic [NPC_W-1:0] br_pcsel;

  ctl_table u_table (
    .addr (op_code),
    .word (base_w)
  );

  ctl_branch u_branch (
    .op        (op_code),
    .zero      (zero_flag),
    .pcsel_in  (base_w.pcsel),
    .pcsel_out (br_pcsel)
  );

  always_comb begin
    br_w       = base_w;
    br_w.pcsel = br_pcsel;
  end

  ctl_trap u_trap (
    .w_in  (br_w),
    .rst   (rst),
    .irq   (irq_req),
    .sup   (pc_sup),
    .w_out (fin_w)
  );

  assign sel_a       = fin_w.asel;
  assign sel_b       = fin_w.bsel;
  assign sel_rb_addr = fin_w.ra2sel;
  assign alu_fn      = fin_w.alufn;
  assign mem_rd_en   = fin_w.moe;
  assign wd_sel      = fin_w.wdsel;
  assign wa_sel_xp   = fin_w.wasel;
  assign rf_we       = fin_w.werf;
  assign mem_we      = fin_w.wr;
  assign npc_sel     = fin_w.pcsel;
endmodule

// File: rtl/ctl_decoder_checker.sv
module ctl_decoder_checker (
  input logic [5:0] op_code,
  input logic       zero_flag,
  input logic       rst,
  input logic       irq_req,
  input logic       pc_sup,
  input logic       mem_rd_en,
  input logic [1:0] wd_sel,
  input logic       wa_sel_xp,
  input logic       rf_we,
  input logic       mem_we,
  input logic [2:0] npc_sel
);
  logic irq_live;
  assign irq_live = irq_req & ~pc_sup;

  always_comb begin
    assert_reset_blocks_writes_R11: assert (!rst || (!mem_we && !rf_we))
      else $error("reset let a write through");
    assert_irq_taken_R9: assert (!irq_live ||
        (npc_sel == 3'b100 && wa_sel_xp && wd_sel == 2'b00 && !mem_we))
      else $error("interrupt not injected");
    assert_irq_masked_R10: assert (!pc_sup || npc_sel != 3'b100)
      else $error("interrupt taken in supervisor mode");
    assert_beq_resolve_R5: assert (op_code != 6'b011101 || irq_live ||
        npc_sel == (zero_flag ? 3'b001 : 3'b000))
      else $error("equal branch misresolved");
    assert_bne_resolve_R6: assert (op_code != 6'b011110 || irq_live ||
        npc_sel == (zero_flag ? 3'b000 : 3'b001))
      else $error("not-equal branch misresolved");
    assert_store_write_R3: assert (op_code != 6'b011001 || rst || irq_live || mem_we)
      else $error("store lost its write");
    assert_no_read_and_write_R2: assert (!(mem_rd_en && mem_we))
      else $error("memory read and write together");
  end
endmodule

bind ctl_decoder ctl_decoder_checker u_checker (
  .op_code   (op_code),
  .zero_flag (zero_flag),
  .rst       (rst),
  .irq_req   (irq_req),
  .pc_sup    (pc_sup),
  .mem_rd_en (mem_rd_en),
  .wd_sel    (wd_sel),
  .wa_sel_xp (wa_sel_xp),
  .rf_we     (rf_we),
  .mem_we    (mem_we),
  .npc_sel   (npc_sel)
);

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic [5:0] op_code = '0;
  logic       zero_flag = 1'b0;
  logic       rst = 1'b1;
  logic       irq_req = 1'b0;
  logic       pc_sup = 1'b0;
  logic       sel_a, sel_b, sel_rb_addr, mem_rd_en, wa_sel_xp, rf_we, mem_we;
  logic [5:0] alu_fn;
  logic [1:0] wd_sel;
  logic [2:0] npc_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_decoder u_dut (
    .op_code(op_code), .zero_flag(zero_flag), .rst(rst), .irq_req(irq_req),
    .pc_sup(pc_sup), .sel_a(sel_a), .sel_b(sel_b), .sel_rb_addr(sel_rb_addr),
    .alu_fn(alu_fn), .mem_rd_en(mem_rd_en), .wd_sel(wd_sel),
    .wa_sel_xp(wa_sel_xp), .rf_we(rf_we), .mem_we(mem_we), .npc_sel(npc_sel)
  );

  // Packed as {npc 3, wa 1, a 1, rb 1, b 1, fn 6, wd 2, rfwe 1, rd 1, we 1}.
  function automatic logic [17:0] pack(input logic [2:0] npc, input logic wa,
      input logic a, input logic rb, input logic b, input logic [5:0] fn,
      input logic [1:0] wd, input logic rfwe, input logic rd, input logic we);
    return {npc, wa, a, rb, b, fn, wd, rfwe, rd, we};
  endfunction

  // R8 nibble map; bit 6 marks a defined nibble.
  function automatic logic [6:0] fn_ref(input int nib);
    int codes [16] = '{0, 1, 2, -1, 51, 53, 55, -1, 24, 30, 22, 25, 32, 33, 35, -1};
    if (codes[nib] < 0) return 7'd0;
    return {1'b1, 6'(codes[nib])};
  endfunction

  function automatic logic [17:0] model(input int op, input logic z, input logic r,
      input logic q, input logic s, output string tag);
    logic [17:0] e;
    logic [6:0]  f;
    e   = pack(3'b011, 1, 0, 0, 0, 6'd0, 2'b00, 1, 0, 0);  // R1
    tag = "R1";
    if (op >= 32) begin
      f = fn_ref(op % 16);
      if (f[6]) begin
        e   = pack(3'b000, 0, 0, 0, (op >= 48), f[5:0], 2'b01, 1, 0, 0);
        tag = "R8";
      end
    end else if (op == 24) begin e = pack(0, 0, 0, 0, 1, 6'd0, 2'b10, 1, 1, 0); tag = "R2"; end
    else if (op == 25) begin e = pack(0, 0, 0, 1, 1, 6'd0, 2'b00, 0, 0, 1); tag = "R3"; end
    else if (op == 27) begin e = pack(3'b010, 0, 0, 0, 0, 6'd0, 2'b00, 1, 0, 0); tag = "R4"; end
    else if (op == 29) begin e = pack(z ? 3'b001 : 3'b000, 0, 0, 0, 0, 6'd0, 2'b00, 1, 0, 0); tag = "R5"; end
    else if (op == 30) begin e = pack(z ? 3'b000 : 3'b001, 0, 0, 0, 0, 6'd0, 2'b00, 1, 0, 0); tag = "R6"; end
    else if (op == 31) begin e = pack(0, 0, 1, 0, 0, 6'b011010, 2'b10, 1, 1, 0); tag = "R7"; end
    if (q && !s) begin
      e[17:15] = 3'b100; e[14] = 1'b1; e[2] = 1'b1; e[4:3] = 2'b00; e[0] = 1'b0;
      tag = "R9";
    end else if (q && s) begin
      tag = "R10";
    end
    if (r) begin
      e[0] = 1'b0; e[2] = 1'b0;
      tag = "R11";
    end
    return e;
  endfunction

  task automatic apply(input int op, input logic z, input logic r,
      input logic q, input logic s);
    logic [17:0] exp_w, got_w;
    string tag;
    @(negedge clk);
    op_code = 6'(op); zero_flag = z; rst = r; irq_req = q; pc_sup = s;
    #(CLK_PERIOD/4);
    exp_w = model(op, z, r, q, s, tag);
    got_w = pack(npc_sel, wa_sel_xp, sel_a, sel_rb_addr, sel_b, alu_fn,
                 wd_sel, rf_we, mem_rd_en, mem_we);
    n_checks++;
    if (got_w !== exp_w) begin
      n_fail++;
      $display("FAIL %s op=%b z=%b rst=%b irq=%b sup=%b got=%h exp=%h",
               tag, 6'(op), z, r, q, s, got_w, exp_w);
    end
  endtask

  initial begin
    // Reset state first: R11 with a pending store and an unmasked interrupt.
    apply(25, 0, 1, 0, 0);
    apply(25, 0, 1, 1, 0);
    // R9/R10 against branches and stores in the same cycle.
    apply(29, 1, 0, 1, 0);
    apply(30, 0, 0, 1, 1);
    apply(25, 0, 0, 1, 0);
    // Exhaustive sweep covering R1..R11.
    for (int op = 0; op < 64; op++)
      for (int v = 0; v < 16; v++)
        apply(op, v[0], v[1], v[2], v[3]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule